// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a single requester and a four-bank synchronous DRAM with a 32-bit data bus. After reset it brings the memory up: it holds the clock enable low during reset, waits a power-up period, precharges every bank, runs two refresh cycles and loads the mode register. From then on it serves one word-sized read or write at a time. Each access opens the row, issues the column command with auto-precharge set, and waits until the bank may be opened again.

A refresh timer runs once start-up is complete. When a refresh falls due, the refresh is issued at the next idle point, ahead of any waiting request. All memory timing is given as parameter counts of clock cycles. Read data is captured from the data bus a fixed CAS latency after the memory receives the read command, and is handed back with a one-cycle valid strobe.

The request address is packed as bank in bits [20:19], row in bits [18:8] and column in bits [7:0].

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is held, `sd_cke` is low and the command pins show NOP (CS,RAS,CAS,WE = 0,1,1,1). After release, `sd_cke` goes high on the first clock and stays high. Exactly `T_POWERUP` NOP cycles precede the first other command.
- R2: Start-up order: PRECHARGE (0,0,1,0) with address bit 10 high. `T_RP` cycles later, AUTO REFRESH (0,0,0,1). `T_RC` cycles later, a second AUTO REFRESH. `T_RC` cycles after that, MODE SET (0,0,0,0). Nothing but NOP follows for `T_MRD` cycles.
- R3: The MODE SET cycle drives the bank pins to 0. Address bits [6:4] carry `CAS_LAT` and every other address bit is 0, which selects burst length 1 and sequential order.
- R4: A refresh falls due every `REF_INTERVAL` cycles, counted from the clock after MODE SET. A due refresh is issued at the first idle slot, ahead of a waiting request. No command follows an AUTO REFRESH within `T_RC` cycles.
- R5: An access issues ACTIVE (0,0,1,1) with the bank from `req_addr[20:19]` and the row from `req_addr[18:8]`. Exactly `T_RCD` cycles later it issues READ (0,1,0,1) or WRITE (0,1,0,0) to the same bank. That command has address bit 10 high, bits [9:8] low and the column from `req_addr[7:0]`.
- R6: In the WRITE cycle, `sd_dq` carries the write data and `sd_dqm` equals the inverted byte enables. On every other cycle `sd_dqm` is 0.
- R7: `rd_valid` is high for exactly one cycle, `CAS_LAT`+1 cycles after READ appears on the pins. `rd_data` then holds the word the memory drove `CAS_LAT` cycles after it received the READ.
- R8: After READ, the next command comes no earlier than max(`T_RC`-`T_RCD`, `CAS_LAT`+1) cycles later. After WRITE, it comes no earlier than max(`T_RC`-`T_RCD`, `T_WR`+`T_RP`) cycles later. Between commands the pins show NOP.
- R9: `req_ready` is high only in the cycle a request is taken. That cycle is the first one that is idle, past every spacing rule, after start-up, with no refresh due, and with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address {bank, row, column} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for a write |
| req_ready | output | 1 | Request taken this cycle |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Captured read data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 11 | Multiplexed row/column address |
| sd_dqm | output | 4 | Byte mask lanes |
| sd_dq | inout | 32 | Bidirectional data bus |

## Verification
The in-line properties check the following on every cycle:
- ACTIVE-to-column spacing, measured at the pins.
- Quiet time after each refresh.
- The auto-precharge and all-banks bits.
- Data bus ownership, and the read strobe arriving exactly CAS-latency-plus-one cycles after a READ.
- That the refresh acknowledge only comes while a refresh is pending.

Some behaviours only the bench scenarios can show:
- The exact start-up sequence and the mode field.
- Refresh winning over a waiting request.
- Byte-masked writes reading back merged data.
- The precise cycle at which each request is taken.

The bench shows these by comparing every pin against its own behavioural timeline of the memory command stream.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IREF1,
        ST_IREF2,
        ST_MODE,
        ST_IDLE,
        ST_COL
    } ctl_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int unsigned INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack,
    output logic pending
);
    localparam int RW = $clog2(INTERVAL);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t r_q, r_d;
    logic wrap;

    always_comb begin
        r_d  = r_q;
        wrap = en && (r_q.cnt == RW'(INTERVAL - 1));
        if (en) r_d.cnt = wrap ? '0 : r_q.cnt + 1'b1;
        r_d.pend = wrap | (r_q.pend & ~ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pending = r_q.pend;

    // R4: the sequencer only acknowledges a refresh that is actually due
    assert_ack_when_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> r_q.pend);

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int unsigned CAS_LAT = 2,
    parameter int unsigned DW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [CAS_LAT:0] stg;
        logic             v;
        logic [DW-1:0]    d;
    } cap_t;

    cap_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.stg = {r_q.stg[CAS_LAT-1:0], issue};
        r_d.v   = r_q.stg[CAS_LAT];
        if (r_q.stg[CAS_LAT]) r_d.d = dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.v;
    assign rd_data  = r_q.d;

endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
    import sdram_seq_pkg::*;
#(
    parameter int unsigned DW        = 32,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned ROW_W     = 11,
    parameter int unsigned COL_W     = 8,
    parameter int unsigned T_POWERUP = 20000,
    parameter int unsigned T_RP      = 2,
    parameter int unsigned T_RC      = 7,
    parameter int unsigned T_RCD     = 2,
    parameter int unsigned T_MRD     = 2,
    parameter int unsigned T_WR      = 2,
    parameter int unsigned CAS_LAT   = 2,
    localparam int unsigned AW       = BA_W + ROW_W + COL_W,
    localparam int unsigned BEW      = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [BEW-1:0]   req_be,
    output logic             req_ready,
    input  logic             ref_pending,
    output logic             ref_ack,
    output logic             init_done,
    output logic             rd_issue,
    output logic             cke,
    output logic [3:0]       cmd,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr,
    output logic [BEW-1:0]   dqm,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);
    localparam int unsigned AP_BIT = 10;
    localparam int unsigned GAP_RD = max2(T_RC - T_RCD, CAS_LAT + 1);
    localparam int unsigned GAP_WR = max2(T_RC - T_RCD, T_WR + T_RP);
    localparam int unsigned MAXC   = max2(max2(max2(T_POWERUP, T_RC), max2(GAP_RD, GAP_WR)),
                                          max2(max2(T_RP, T_RCD), T_MRD));
    localparam int CW = $clog2(MAXC + 1);

    typedef struct packed {
        ctl_state_e       st;
        logic [CW-1:0]    cnt;
        sd_cmd_e          cmd;
        logic [BA_W-1:0]  ba;
        logic [ROW_W-1:0] a;
        logic [BEW-1:0]   dqm;
        logic [DW-1:0]    wd;
        logic             oe;
        logic             cke;
        logic             done;
        logic             lwr;
        logic [BA_W-1:0]  lbank;
        logic [COL_W-1:0] lcol;
        logic [DW-1:0]    lwd;
        logic [BEW-1:0]   lbe;
    } fsm_t;

    fsm_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.cmd   = CMD_NOP;
        r_d.ba    = '0;
        r_d.a     = '0;
        r_d.dqm   = '0;
        r_d.oe    = 1'b0;
        r_d.cke   = 1'b1;
        req_ready = 1'b0;
        ref_ack   = 1'b0;
        rd_issue  = 1'b0;
        if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end else begin
            unique case (r_q.st)
                ST_PWRUP: begin
                    r_d.cmd       = CMD_PRE;
                    r_d.a[AP_BIT] = 1'b1;
                    r_d.st        = ST_IREF1;
                    r_d.cnt       = CW'(T_RP - 1);
                end
                ST_IREF1: begin
                    r_d.cmd = CMD_REF;
                    r_d.st  = ST_IREF2;
                    r_d.cnt = CW'(T_RC - 1);
                end
                ST_IREF2: begin
                    r_d.cmd = CMD_REF;
                    r_d.st  = ST_MODE;
                    r_d.cnt = CW'(T_RC - 1);
                end
                ST_MODE: begin
                    r_d.cmd    = CMD_MRS;
                    r_d.a[6:4] = 3'(CAS_LAT);
                    r_d.st     = ST_IDLE;
                    r_d.cnt    = CW'(T_MRD - 1);
                    r_d.done   = 1'b1;
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        r_d.cmd = CMD_REF;
                        ref_ack = 1'b1;
                        r_d.cnt = CW'(T_RC - 1);
                    end else if (req_valid) begin
                        req_ready = 1'b1;
                        r_d.cmd   = CMD_ACT;
                        r_d.ba    = req_addr[AW-1 -: BA_W];
                        r_d.a     = req_addr[COL_W +: ROW_W];
                        r_d.lbank = req_addr[AW-1 -: BA_W];
                        r_d.lcol  = req_addr[COL_W-1:0];
                        r_d.lwr   = req_write;
                        r_d.lwd   = req_wdata;
                        r_d.lbe   = req_be;
                        r_d.st    = ST_COL;
                        r_d.cnt   = CW'(T_RCD - 1);
                    end
                end
                ST_COL: begin
                    r_d.ba              = r_q.lbank;
                    r_d.a[AP_BIT]       = 1'b1;
                    r_d.a[COL_W-1:0]    = r_q.lcol;
                    r_d.st              = ST_IDLE;
                    if (r_q.lwr) begin
                        r_d.cmd = CMD_WR;
                        r_d.oe  = 1'b1;
                        r_d.wd  = r_q.lwd;
                        r_d.dqm = ~r_q.lbe;
                        r_d.cnt = CW'(GAP_WR - 1);
                    end else begin
                        r_d.cmd  = CMD_RD;
                        rd_issue = 1'b1;
                        r_d.cnt  = CW'(GAP_RD - 1);
                    end
                end
                default: r_d.st = ST_PWRUP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_PWRUP;
            r_q.cnt <= CW'(T_POWERUP);
            r_q.cmd <= CMD_NOP;
        end else begin
            r_q <= r_d;
        end
    end

    assign cke       = r_q.cke;
    assign cmd       = r_q.cmd;
    assign ba        = r_q.ba;
    assign addr      = r_q.a;
    assign dqm       = r_q.dqm;
    assign dq_out    = r_q.wd;
    assign dq_oe     = r_q.oe;
    assign init_done = r_q.done;

    // Checker state: cycles since the last ACTIVE / AUTO REFRESH seen on the pins
    localparam logic [CW-1:0] SAT = '1;
    logic [CW-1:0] since_act_q, since_ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act_q <= SAT;
            since_ref_q <= SAT;
        end else begin
            since_act_q <= (r_q.cmd == CMD_ACT) ? CW'(1) :
                           (since_act_q == SAT) ? SAT : since_act_q + 1'b1;
            since_ref_q <= (r_q.cmd == CMD_REF) ? CW'(1) :
                           (since_ref_q == SAT) ? SAT : since_ref_q + 1'b1;
        end
    end

    assert_rcd_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_RD || r_q.cmd == CMD_WR) |-> (since_act_q == CW'(T_RCD)));

    assert_autoprecharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_RD || r_q.cmd == CMD_WR) |-> (r_q.a[AP_BIT] && r_q.a[9:8] == 2'b00));

    assert_precharge_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_PRE) |-> r_q.a[AP_BIT]);

    assert_refresh_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd != CMD_NOP) |-> (since_ref_q >= CW'(T_RC)));

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int unsigned DW           = 32,
    parameter int unsigned BA_W         = 2,
    parameter int unsigned ROW_W        = 11,
    parameter int unsigned COL_W        = 8,
    parameter int unsigned T_POWERUP    = 20000,
    parameter int unsigned T_RP         = 2,
    parameter int unsigned T_RC         = 7,
    parameter int unsigned T_RCD        = 2,
    parameter int unsigned T_MRD        = 2,
    parameter int unsigned T_WR         = 2,
    parameter int unsigned CAS_LAT      = 2,
    parameter int unsigned REF_INTERVAL = 1560,
    localparam int unsigned AW          = BA_W + ROW_W + COL_W,
    localparam int unsigned BEW         = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [BEW-1:0]   req_be,
    output logic             req_ready,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr,
    output logic [BEW-1:0]   sd_dqm,
    inout  wire  [DW-1:0]    sd_dq
);
    logic          ref_pending, ref_ack, init_done, rd_issue, dq_oe;
    logic [3:0]    pin_cmd;
    logic [DW-1:0] dq_out;

    sdr_cmd_fsm #(
        .DW(DW), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .T_POWERUP(T_POWERUP), .T_RP(T_RP), .T_RC(T_RC), .T_RCD(T_RCD),
        .T_MRD(T_MRD), .T_WR(T_WR), .CAS_LAT(CAS_LAT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .ref_pending(ref_pending), .ref_ack(ref_ack), .init_done(init_done),
        .rd_issue(rd_issue), .cke(sd_cke), .cmd(pin_cmd), .ba(sd_ba),
        .addr(sd_addr), .dqm(sd_dqm), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst_n(rst_n), .en(init_done), .ack(ref_ack), .pending(ref_pending)
    );

    sdr_rd_capture #(.CAS_LAT(CAS_LAT), .DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .issue(rd_issue), .dq_in(sd_dq),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pin_cmd;
    assign sd_dq = dq_oe ? dq_out : {DW{1'bz}};

    assert_cke_stays_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sd_cke) |-> sd_cke);

    assert_dq_drive_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (pin_cmd == 4'(CMD_WR)));

    assert_dqm_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != 4'(CMD_WR)) |-> (sd_dqm == '0));

    assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(pin_cmd, CAS_LAT + 1) == 4'(CMD_RD)));

    assert_read_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pin_cmd, CAS_LAT + 1) == 4'(CMD_RD)) |-> rd_valid);

endmodule

// File: tb/sim_sdram_seq_ctrl.sv
module sim_sdram_seq_ctrl;
    localparam int TPU  = 10;
    localparam int TRP  = 2;
    localparam int TRC  = 7;
    localparam int TRCD = 2;
    localparam int TMRD = 2;
    localparam int TWR  = 3;
    localparam int CL   = 3;
    localparam int RINT = 70;
    localparam int GAP_RD = ((TRC - TRCD) > (CL + 1)) ? (TRC - TRCD) : (CL + 1);
    localparam int GAP_WR = ((TRC - TRCD) > (TWR + TRP)) ? (TRC - TRCD) : (TWR + TRP);
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MRS = 4'b0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [31:0] rd_data;
    logic [1:0]  sd_ba;
    logic [10:0] sd_addr;
    logic [3:0]  sd_dqm;
    wire  [31:0] sd_dq;
    logic        mem_oe = 1'b0;
    logic [31:0] mem_drv = '0;

    assign sd_dq = mem_oe ? mem_drv : 32'bz;

    always #4 clk = ~clk;

    sdram_seq_ctrl #(
        .T_POWERUP(TPU), .T_RP(TRP), .T_RC(TRC), .T_RCD(TRCD), .T_MRD(TMRD),
        .T_WR(TWR), .CAS_LAT(CL), .REF_INTERVAL(RINT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq(sd_dq)
    );

    int vectors = 0, miscompares = 0, ecount = 0;
    bit done = 1'b0;

    // expected pin timeline, keyed by clock index after reset release
    logic [3:0]  e_cmd[int];
    logic [1:0]  e_ba[int];
    logic [10:0] e_a[int];
    logic [3:0]  e_dqm[int];
    logic [31:0] e_wd[int];
    logic [31:0] e_rd[int];
    string       e_tag[int];
    logic [31:0] ref_mem[int];
    logic [31:0] dev_mem[int];
    logic [31:0] dev_drv[int];
    logic [10:0] dev_row[4];
    int free_at, ref_due;

    function automatic logic [31:0] seed_word(input int k);
        return (k * 32'h9E37) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] mask_merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                               input logic [3:0] keep);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = keep[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        return r;
    endfunction

    task automatic put(input int k, input logic [3:0] c, input logic [1:0] b,
                       input logic [10:0] a, input string t);
        e_cmd[k] = c; e_ba[k] = b; e_a[k] = a; e_tag[k] = t;
    endtask

    task automatic check(input string tag, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at clock %0d: actual %h expected %h", tag, what, ecount, act, exp);
        end
    endtask

    initial begin
        int p, m;
        p = TPU + 1;
        put(p, C_PRE, 2'd0, 11'h400, "R2");
        put(p + TRP, C_REF, 2'd0, 11'h000, "R2");
        put(p + TRP + TRC, C_REF, 2'd0, 11'h000, "R2");
        m = p + TRP + 2 * TRC;
        put(m, C_MRS, 2'd0, 11'(CL << 4), "R3");
        free_at = m + TMRD;
        ref_due = m + RINT + 1;
    end

    always @(posedge clk) if (rst_n) ecount <= ecount + 1;

    // memory device model: reacts to the pins shown after each edge
    always @(posedge clk) begin
        int k;
        #1;
        mem_oe = dev_drv.exists(ecount);
        if (mem_oe) mem_drv = dev_drv[ecount];
        if (rst_n) begin
            case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
                C_ACT: dev_row[sd_ba] = sd_addr;
                C_WR: begin
                    k = {sd_ba, dev_row[sd_ba], sd_addr[7:0]};
                    dev_mem[k] = mask_merge(dev_mem.exists(k) ? dev_mem[k] : seed_word(k),
                                            sd_dq, ~sd_dqm);
                end
                C_RD: begin
                    k = {sd_ba, dev_row[sd_ba], sd_addr[7:0]};
                    dev_drv[ecount + CL] = dev_mem.exists(k) ? dev_mem[k] : seed_word(k);
                end
                default: ;
            endcase
        end
    end

    // reference model and per-clock comparison
    always @(negedge clk) begin
        int n, e, k;
        logic [3:0] xc;
        logic rdy;
        string tg;
        n = ecount;
        e = n + 1;
        check("R1", "cke", {63'd0, sd_cke}, {63'd0, (n >= 1)});
        xc = e_cmd.exists(n) ? e_cmd[n] : C_NOP;
        tg = e_tag.exists(n) ? e_tag[n] : (n <= TPU ? "R1" : "R8");
        check(tg, "command", {60'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {60'd0, xc});
        if (rst_n) begin
            check(tg, "bank/address", {51'd0, sd_ba, sd_addr},
                  {51'd0, e_ba.exists(n) ? e_ba[n] : 2'd0, e_a.exists(n) ? e_a[n] : 11'd0});
            check("R6", "dqm", {60'd0, sd_dqm}, {60'd0, e_dqm.exists(n) ? e_dqm[n] : 4'd0});
            if (e_wd.exists(n)) check("R6", "write data", {32'd0, sd_dq}, {32'd0, e_wd[n]});
            check("R7", "rd_valid", {63'd0, rd_valid}, {63'd0, e_rd.exists(n)});
            if (e_rd.exists(n)) check("R7", "rd_data", {32'd0, rd_data}, {32'd0, e_rd[n]});
            rdy = 1'b0;
            if (e >= free_at) begin
                if (e >= ref_due) begin
                    put(e, C_REF, 2'd0, 11'd0, "R4");
                    free_at = e + TRC;
                    ref_due = ref_due + RINT;
                end else if (req_valid) begin
                    rdy = 1'b1;
                    k = req_addr;
                    put(e, C_ACT, req_addr[20:19], req_addr[18:8], "R5");
                    if (req_write) begin
                        put(e + TRCD, C_WR, req_addr[20:19], {3'b100, req_addr[7:0]}, "R5");
                        e_dqm[e + TRCD] = ~req_be;
                        e_wd[e + TRCD]  = req_wdata;
                        ref_mem[k] = mask_merge(ref_mem.exists(k) ? ref_mem[k] : seed_word(k),
                                                req_wdata, req_be);
                        free_at = e + TRCD + GAP_WR;
                    end else begin
                        put(e + TRCD, C_RD, req_addr[20:19], {3'b100, req_addr[7:0]}, "R5");
                        e_rd[e + TRCD + CL + 1] = ref_mem.exists(k) ? ref_mem[k] : seed_word(k);
                        free_at = e + TRCD + GAP_RD;
                    end
                end
            end
            check("R9", "req_ready", {63'd0, req_ready}, {63'd0, rdy});
        end
    end

    task automatic do_req(input bit wr, input logic [20:0] ad, input logic [31:0] wd,
                          input logic [3:0] be);
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd; req_be = be;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int cycles);
        repeat (cycles) @(posedge clk);
    endtask

    initial begin
        idle(3);
        #2 rst_n = 1'b1;
        // R9: request raised during start-up must wait for idle
        do_req(1'b1, {2'd0, 11'h012, 8'h34}, 32'hDEAD_BEEF, 4'hF);
        // R5: each bank, different rows and columns
        do_req(1'b1, {2'd1, 11'h7FF, 8'hFF}, 32'h1111_2222, 4'hF);
        do_req(1'b1, {2'd2, 11'h400, 8'h01}, 32'h3333_4444, 4'hF);
        do_req(1'b1, {2'd3, 11'h001, 8'h80}, 32'h5555_6666, 4'hF);
        // R6: byte-masked write merges with earlier contents
        do_req(1'b1, {2'd0, 11'h012, 8'h34}, 32'hA5A5_A5A5, 4'b0101);
        // R7: read-back of written words and of a never-written word
        do_req(1'b0, {2'd0, 11'h012, 8'h34}, 32'h0, 4'h0);
        do_req(1'b0, {2'd1, 11'h7FF, 8'hFF}, 32'h0, 4'h0);
        do_req(1'b0, {2'd3, 11'h001, 8'h80}, 32'h0, 4'h0);
        do_req(1'b0, {2'd2, 11'h155, 8'h2A}, 32'h0, 4'h0);
        // R4: idle long enough for periodic refreshes
        idle(2 * RINT + 5);
        // R4/R8: back-to-back stream crossing refresh slots
        for (int i = 0; i < 24; i++)
            do_req(i[0], {i[1:0], 11'(i * 37), 8'(i * 11)}, 32'hC000_0000 + i, 4'(i + 1));
        idle(20);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule